// File: doc/BRIEF.md
# Four-Channel DMA Transfer Sequencer

The block runs block transfers for a four-channel DMA controller. A channel that has a request and a clear mask bit, or one that software asks for, wins by fixed priority (lowest index first). The block then raises a bus hold request and waits for the hold acknowledge. After that it steps through an upper-address strobe state and one transfer cycle per word. In each transfer cycle it drives the memory read or memory write strobe and an acknowledge to the peripheral. The acknowledge polarity can be programmed. Each channel keeps a base and a current address, and a base and a current count.

A service ends in one of two ways. One is terminal count, when the current count wraps from zero. The other is an external end-of-process input that is low during a transfer. At the end the block updates the channel's terminal-count status and its mask. Channels set to autoinitialize reload their current registers from the base registers. A memory-to-memory mode pairs channel 0 (source) with channel 1 (destination). In this mode only channel 1 ends the service. Channels marked 16-bit in 16-bit mode step by two and issue even addresses only.

Top module: `dma4_seq`

## Requirements
- R1: `hold_req` rises only after a cycle where some channel has `dreq` high with its mask bit clear, or has `sw_req` high. When several channels are pending, the lowest index is served first.
- R2: `aen` is high only while `hold_req` is high. It rises only after `hold_ack` was seen high, and stays high through the strobe and transfer cycles of the service.
- R3: In a transfer cycle of channel n, exactly one of `rd_n` and `wr_n` is low. `rd_n` is low when bit n of the direction register (address 11) is 1, and `wr_n` is low otherwise. The acknowledge of channel n is active and all other acknowledges are inactive.
- R4: After reset all `dack` bits are high, which means inactive (active-low). When control bit 2 (address 12) is 1, the acknowledges become active-high.
- R5: A channel programmed with count N performs N+1 transfers. `eop_out_n` is low in the last transfer cycle only.
- R6: The first transfer uses the programmed address. Each later transfer adds 2 when control bit 1 (16-bit mode) is set and the channel's bit in the width register (address 10) is 1; otherwise it adds 1. In that 16-bit case `addr[0]` is driven 0.
- R7: A strobe cycle (`adstb` high) comes before the first transfer of a normal service. After that, a strobe cycle comes only before a transfer whose `addr[15:8]` differs from that of the previous transfer.
- R8: `width_n` is 0 during a strobe cycle of a 16-bit channel in 16-bit mode. It is 1 at all other times.
- R9: If `eop_in_n` is low during a transfer cycle, the service ends after that transfer. No `eop_out_n` pulse is issued unless that transfer is also the terminal one.
- R10: When a service ends, the channel's `tc_out` bit is set. Its `mask_out` bit is set unless autoinitialize (address 9) is set for that channel. In that case the current address and count are reloaded from the base values. Without autoinitialize the current registers keep the point where the service stopped.
- R11: With control bit 0 set, a channel-0 request starts a memory-to-memory service. Read cycles at channel 0's address alternate with write cycles at channel 1's address. No acknowledge and no strobe are issued. Channel 0 reaching terminal count sets its `tc_out` bit but does not end the service and does not pulse `eop_out_n`. Channel 1 reaching terminal count pulses `eop_out_n` and ends the service.
- R12: Register writes use these addresses:
  - 0–3: the address of channel n (base and current).
  - 4–7: the count of channel n.
  - 8: the mask (all ones after reset).
  - 13: clears all `tc_out` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| dreq | input | 4 | Peripheral requests |
| sw_req | input | 4 | Software requests |
| hold_req | output | 1 | Bus hold request |
| hold_ack | input | 1 | Bus hold acknowledge |
| eop_in_n | input | 1 | External end-of-process, active low |
| eop_out_n | output | 1 | Generated end-of-process, active low |
| dack | output | 4 | Peripheral acknowledges, programmable polarity |
| aen | output | 1 | Address enable |
| adstb | output | 1 | Upper-address strobe |
| addr | output | 16 | Transfer address |
| rd_n | output | 1 | Memory read, active low |
| wr_n | output | 1 | Memory write, active low |
| width_n | output | 1 | Width indication, 0 for 16-bit |
| mask_out | output | 4 | Channel mask bits |
| tc_out | output | 4 | Terminal-count status bits |

## Verification
Every output is registered state or decoded directly from registered state, so the value for a given cycle appears in the same cycle the state is entered. A request is presented at a falling edge. `hold_req` follows one edge later. The strobe and the first transfer follow on the edges after `hold_ack` has been seen. The bench drives inputs and samples `addr`, `dack`, the strobes and `eop_out_n` at falling edges only, one transfer per cycle in which `aen` is high and `adstb` is low. It reads `mask_out` and `tc_out` once `hold_req` has fallen, which is the edge after the terminal transfer. An end-of-process input driven during a transfer cycle takes effect at the next rising edge, so the bench expects exactly that transfer to be the last one.

// File: rtl/dma4_seq.sv
module dma4_seq #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [3:0]     reg_addr,
  input  logic [15:0]    reg_wdata,
  input  logic [NCH-1:0] dreq,
  input  logic [NCH-1:0] sw_req,
  output logic           hold_req,
  input  logic           hold_ack,
  input  logic           eop_in_n,
  output logic           eop_out_n,
  output logic [NCH-1:0] dack,
  output logic           aen,
  output logic           adstb,
  output logic [AW-1:0]  addr,
  output logic           rd_n,
  output logic           wr_n,
  output logic           width_n,
  output logic [NCH-1:0] mask_out,
  output logic [NCH-1:0] tc_out
);
  localparam int IW = $clog2(NCH);
  localparam logic [3:0] A_CNT  = 4'(NCH);
  localparam logic [3:0] A_MASK = 4'(2*NCH);
  localparam logic [3:0] A_AUTO = A_MASK + 4'd1;
  localparam logic [3:0] A_WIDE = A_MASK + 4'd2;
  localparam logic [3:0] A_DIR  = A_MASK + 4'd3;
  localparam logic [3:0] A_CTRL = A_MASK + 4'd4;
  localparam logic [3:0] A_CLR  = A_MASK + 4'd5;

  typedef enum logic [1:0] {IDLE, HOLD, STB, XFER} st_t;
  st_t st;

  logic [AW-1:0]  b_addr [NCH];
  logic [AW-1:0]  c_addr [NCH];
  logic [CW-1:0]  b_cnt  [NCH];
  logic [CW-1:0]  c_cnt  [NCH];
  logic [NCH-1:0] mask, tc_st, auto_en, wide, dir_rd;
  logic           m2m, mode16, dack_hi, svc_m2m, ph;
  logic [IW-1:0]  ch, win;
  logic [AW-9:0]  last_hi;

  wire [NCH-1:0] pend = (dreq & ~mask) | sw_req;

  always_comb begin
    win = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (pend[i]) win = IW'(i);
  end

  wire [IW-1:0] cur     = (svc_m2m && ph) ? IW'(1) : ch;
  wire          is_wide = mode16 & wide[cur];
  wire [AW-1:0] a_raw   = c_addr[cur];
  wire [AW-1:0] na      = a_raw + (is_wide ? AW'(2) : AW'(1));
  wire          last    = (c_cnt[cur] == '0);
  wire          in_x    = (st == XFER);
  wire          tc_end  = in_x && last && !(svc_m2m && !ph);
  wire          done    = tc_end || (in_x && !eop_in_n);
  wire [NCH-1:0] ack_v  = (in_x && !svc_m2m) ? (NCH'(1) << ch) : '0;

  assign addr      = is_wide ? {a_raw[AW-1:1], 1'b0} : a_raw;
  assign hold_req  = (st != IDLE);
  assign aen       = (st == STB) || in_x;
  assign adstb     = (st == STB);
  assign eop_out_n = !tc_end;
  assign dack      = dack_hi ? ack_v : ~ack_v;
  assign rd_n      = !(in_x && (svc_m2m ? !ph : dir_rd[ch]));
  assign wr_n      = !(in_x && (svc_m2m ? ph : !dir_rd[ch]));
  assign width_n   = !((st == STB) && is_wide);
  assign mask_out  = mask;
  assign tc_out    = tc_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      for (int i = 0; i < NCH; i++) begin
        b_addr[i] <= '0; c_addr[i] <= '0; b_cnt[i] <= '0; c_cnt[i] <= '0;
      end
      mask <= '1; tc_st <= '0; auto_en <= '0; wide <= '0; dir_rd <= '0;
      m2m <= 1'b0; mode16 <= 1'b0; dack_hi <= 1'b0;
      svc_m2m <= 1'b0; ph <= 1'b0; ch <= '0; last_hi <= '0;
    end else begin
      if (reg_we) begin
        if (reg_addr < A_CNT) begin
          b_addr[reg_addr[IW-1:0]] <= reg_wdata[AW-1:0];
          c_addr[reg_addr[IW-1:0]] <= reg_wdata[AW-1:0];
        end else if (reg_addr < A_MASK) begin
          b_cnt[reg_addr[IW-1:0]] <= reg_wdata[CW-1:0];
          c_cnt[reg_addr[IW-1:0]] <= reg_wdata[CW-1:0];
        end else begin
          case (reg_addr)
            A_MASK: mask    <= reg_wdata[NCH-1:0];
            A_AUTO: auto_en <= reg_wdata[NCH-1:0];
            A_WIDE: wide    <= reg_wdata[NCH-1:0];
            A_DIR:  dir_rd  <= reg_wdata[NCH-1:0];
            A_CTRL: {dack_hi, mode16, m2m} <= reg_wdata[2:0];
            A_CLR:  tc_st   <= '0;
            default: ;
          endcase
        end
      end
      case (st)
        IDLE: if (|pend) begin
          ch      <= win;
          svc_m2m <= m2m && (win == '0);
          ph      <= 1'b0;
          st      <= HOLD;
        end
        HOLD: if (hold_ack) st <= svc_m2m ? XFER : STB;
        STB: begin
          last_hi <= addr[AW-1:8];
          st      <= XFER;
        end
        XFER: begin
          c_addr[cur] <= na;
          c_cnt[cur]  <= c_cnt[cur] - CW'(1);
          if (svc_m2m && !ph && last) tc_st[0] <= 1'b1;
          if (done) begin
            st         <= IDLE;
            tc_st[cur] <= 1'b1;
            if (auto_en[cur]) begin
              c_addr[cur] <= b_addr[cur];
              c_cnt[cur]  <= b_cnt[cur];
            end else begin
              mask[cur] <= 1'b1;
            end
          end else if (svc_m2m) begin
            ph <= !ph;
          end else if (na[AW-1:8] != last_hi) begin
            st <= STB;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module dma4_seq_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dreq,
  input logic [NCH-1:0] sw_req,
  input logic [NCH-1:0] mask_out,
  input logic           hold_req,
  input logic           hold_ack,
  input logic           aen,
  input logic           adstb,
  input logic           eop_out_n,
  input logic           rd_n,
  input logic           wr_n,
  input logic           width_n
);
  p_hold_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req) |-> $past(|((dreq & ~mask_out) | sw_req)));
  p_aen_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> hold_req);
  p_aen_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aen) |-> $past(hold_ack));
  p_rdwr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> wr_n);
  p_eop_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !eop_out_n |-> (aen && !adstb && !(rd_n && wr_n)));
  p_stb_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adstb |=> (aen && !adstb));
  p_width_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !width_n |-> adstb);
  p_end_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !eop_out_n |=> !aen);
endmodule

bind dma4_seq dma4_seq_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/sim_dma4_seq.sv
module sim_dma4_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [3:0]  dreq = '0, sw_req = '0;
  logic        hold_ack = 1'b0, eop_in_n = 1'b1;
  logic        hold_req, eop_out_n, aen, adstb, rd_n, wr_n, width_n;
  logic [3:0]  dack, mask_out, tc_out;
  logic [15:0] addr;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  dma4_seq u0 (.*);

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic run(input int c, input int start, input int ntr, input bit w16,
                     input int eop_at, input bit hi, input bit rdir);
    int k = 0, stb = 0, eops = 0, exp_stb = 0, prev_hi = -1, raw, expa;
    logic [3:0] oh, expd;
    oh = 4'(1 << c);
    expd = hi ? oh : ~oh;
    dreq[c] = 1'b1;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (adstb) begin
        stb++;
        chk(width_n == !w16, "R8 width_n", width_n, !w16);
      end
      if (aen && !adstb) begin
        raw = (start + k * (w16 ? 2 : 1)) & 16'hffff;
        expa = w16 ? (raw & 16'hfffe) : raw;
        if ((raw >> 8) != prev_hi) exp_stb++;
        prev_hi = raw >> 8;
        chk(addr == 16'(expa), "R6 address", addr, expa);
        chk(dack == expd, "R3 R4 dack", dack, expd);
        chk(rd_n == !rdir && wr_n == rdir, "R3 strobes", {rd_n, wr_n}, {!rdir, rdir});
        if (!eop_out_n) begin
          eops++;
          chk(k == ntr - 1, "R5 eop position", k, ntr - 1);
        end
        eop_in_n = (k == eop_at) ? 1'b0 : 1'b1;
        k++;
        dreq[c] = 1'b0;
      end else eop_in_n = 1'b1;
      hold_ack = hold_req;
      if (k > 0 && !hold_req) break;
    end
    chk(k == ntr, "R5 R9 transfer count", k, ntr);
    chk(stb == exp_stb, "R7 strobe count", stb, exp_stb);
    chk(eops == (eop_at < 0 ? 1 : 0), "R5 R9 eop pulses", eops, (eop_at < 0 ? 1 : 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int st, cn, j, eops;
    bit au, dr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dack == 4'hf, "R4 reset dack", dack, 4'hf);
    chk(!hold_req && !aen, "R2 reset idle", {hold_req, aen}, 0);
    chk(mask_out == 4'hf, "R12 reset mask", mask_out, 4'hf);
    chk(eop_out_n && width_n, "R5 R8 reset levels", {eop_out_n, width_n}, 3);

    wr(12, 2); wr(11, 4'b0101); wr(9, 4'b1010);
    for (int w = 0; w < 2; w++) begin
      wr(10, w ? 4'hf : 4'h0); wr(13, 0); wr(8, 0);
      for (int c = 0; c < 4; c++) begin
        st = 16'h00F9 + c * 16'h0111 + w * 16'h0203;
        cn = 4 + c * 37 + w * 50;
        au = (c % 2) == 1; dr = (c % 2) == 0;
        wr(c, st); wr(4 + c, cn);
        run(c, st, cn + 1, w, -1, 0, dr);
        chk(tc_out[c], "R10 tc set", tc_out[c], 1);
        chk(mask_out[c] == !au, "R10 mask update", mask_out[c], !au);
        if (au) run(c, st, cn + 1, w, -1, 0, dr);
      end
    end

    wr(12, 0); wr(10, 4'hf); wr(8, 0);
    wr(0, 16'h0013); wr(4, 2);
    run(0, 16'h0013, 3, 0, -1, 0, 1);

    wr(12, 4); wr(8, 0);
    wr(3, 16'h20FE); wr(7, 3);
    run(3, 16'h20FE, 4, 0, -1, 1, 0);

    wr(12, 0); wr(13, 0); wr(8, 0);
    wr(2, 16'h1000); wr(6, 9);
    run(2, 16'h1000, 3, 0, 2, 0, 1);
    chk(mask_out[2] && tc_out[2], "R9 R10 ext end status", {mask_out[2], tc_out[2]}, 3);
    wr(13, 0); wr(8, 0);
    run(2, 16'h1003, 7, 0, -1, 0, 1);

    wr(8, 0); wr(1, 16'h0500); wr(5, 1); wr(2, 16'h0600); wr(6, 0);
    dreq[2] = 1'b1;
    run(1, 16'h0500, 2, 0, -1, 0, 0);
    run(2, 16'h0600, 1, 0, -1, 0, 1);

    wr(12, 1); wr(13, 0); wr(8, 4'hf);
    wr(0, 16'h0300); wr(4, 1); wr(1, 16'h0400); wr(5, 3);
    j = 0; eops = 0;
    sw_req[0] = 1'b1;
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      if (adstb) chk(0, "R11 no strobe", 1, 0);
      if (aen && !adstb) begin
        if (j % 2 == 0) begin
          chk(!rd_n && wr_n && addr == 16'h0300 + 16'(j / 2), "R11 read phase", addr, 16'h0300 + j / 2);
        end else begin
          chk(rd_n && !wr_n && addr == 16'h0400 + 16'(j / 2), "R11 write phase", addr, 16'h0400 + j / 2);
        end
        chk(dack == 4'hf, "R11 no dack", dack, 4'hf);
        if (!eop_out_n) begin
          eops++;
          chk(j == 7, "R11 eop on channel 1", j, 7);
        end
        j++;
        sw_req[0] = 1'b0;
      end
      hold_ack = hold_req;
      if (j > 0 && !hold_req) break;
    end
    chk(j == 8, "R11 cycle count", j, 8);
    chk(eops == 1, "R11 eop pulses", eops, 1);
    chk(tc_out[1:0] == 2'b11, "R11 tc status", tc_out[1:0], 3);
    wr(13, 0);
    @(negedge clk);
    chk(tc_out == 4'h0, "R12 tc clear", tc_out, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule